// File: doc/BRIEF.md
# 1-Wire Bus Master Timing Engine

This block times the bit-level waveforms of a 1-Wire bus master. A host issues one operation at a time: a bus reset with presence detection, a single write slot, or a single read slot. The block pulls the shared open-drain line low through an output-enable, releases it, and samples the resynchronised line at fixed instants. When the operation finishes it raises a one-cycle done strobe, together with the presence flag, the sampled bit or a short-circuit flag.

Every duration is a count of clock cycles. Each count is derived at elaboration from a clock-frequency parameter and a set of nanosecond targets. Standard-speed targets are reset low 500 us, presence sample 70 us after release, reset end 480 us after release, write-zero low 65 us, write-one low 6 us, read low 6 us, read sample 13 us and slot 70 us. Overdrive targets are 56, 8, 48, 8, 1, 1, 1.75 and 12 us. The slot length leaves more recovery time than older slaves require. The speed is chosen per operation from a static select input. Byte framing, ROM-level commands and strong pullup belong to a layer above this block.

Top module: `owm_master`

## Requirements
- R1: After reset the block is idle: `line_oe_o`, `busy_o`, `done_o`, `presence_o`, `rbit_o` and `short_o` are all 0.
- R2: A reset operation (`cmd_i` = 2'b00) asserts `line_oe_o` for exactly the reset-low count (500 us standard, 56 us overdrive). `done_o` rises after the reset-low count plus the reset-end count (480 us standard, 48 us overdrive), measured from the accept edge.
- R3: `presence_o` is 1 after a reset exactly when the line is low at the sample instant, 70 us (8 us overdrive) after release. Otherwise it is 0.
- R4: If the line is already low when a reset is accepted, the line is not driven. `busy_o` is high for one cycle, then `done_o` pulses with `short_o` = 1 and `presence_o` = 0.
- R5: A write with `wbit_i` = 0 (`cmd_i` = 2'b01) drives the line low for 65 us (8 us overdrive). `done_o` follows one slot length (70 us, 12 us overdrive) after accept.
- R6: A write with `wbit_i` = 1 drives the line low for 6 us (1 us overdrive), with the same slot length as R5.
- R7: A read (`cmd_i` = 2'b10) drives low for 6 us (1 us overdrive). It samples the line 13 us (1.75 us overdrive) after slot start and reports the sample on `rbit_o` when done, with the same slot length as R5.
- R8: `busy_o` is high from the cycle after accept until `done_o` rises, and falls in that cycle. `done_o` lasts exactly one cycle.
- R9: A command presented while busy is ignored. This includes a change of `od_i`: the running operation keeps its timing, and the line stays released after its done.
- R10: `cmd_i` = 2'b11 is never accepted: `busy_o`, `done_o` and `line_oe_o` stay 0.
- R11: `od_i` = 1 selects overdrive timing and `od_i` = 0 selects standard timing. The value is captured when the command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| od_i | input | 1 | Speed select: 1 overdrive, 0 standard |
| cmd_valid_i | input | 1 | Command request, taken only when idle |
| cmd_i | input | 2 | 00 reset, 01 write, 10 read, 11 reserved |
| wbit_i | input | 1 | Bit to write |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| presence_o | output | 1 | Presence seen by the last reset |
| rbit_o | output | 1 | Bit sampled by the last read |
| short_o | output | 1 | Line was low when the last reset was accepted |
| line_i | input | 1 | Bus line level, asynchronous |
| line_oe_o | output | 1 | Pull bus low when 1 |

## Verification
A wrong phase counter or a wrong speed latch shows at the ports within one operation. It appears as a low time or a slot length that is off by whole cycles, and it is measured edge by edge on `line_oe_o` and `done_o`. A sample taken at the wrong instant flips `presence_o` or `rbit_o`, because the bench slave holds the line low only in a window around the intended sample point. A state that fails to return to idle, or that re-accepts while busy, shows as a stretched or repeated low pulse, or as `busy_o` staying high after `done_o`.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    CMD_RST  = 2'b00,
    CMD_WR   = 2'b01,
    CMD_RD   = 2'b10,
    CMD_RSVD = 2'b11
  } owm_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ABORT,
    S_RST_LOW,
    S_RST_WAIT,
    S_SLOT
  } owm_state_e;

  // timing targets in ns: standard / overdrive
  localparam int unsigned RL_STD_NS = 500_000, RL_OD_NS = 56_000;
  localparam int unsigned PS_STD_NS = 70_000,  PS_OD_NS = 8_000;
  localparam int unsigned RE_STD_NS = 480_000, RE_OD_NS = 48_000;
  localparam int unsigned W0_STD_NS = 65_000,  W0_OD_NS = 8_000;
  localparam int unsigned W1_STD_NS = 6_000,   W1_OD_NS = 1_000;
  localparam int unsigned RD_STD_NS = 6_000,   RD_OD_NS = 1_000;
  localparam int unsigned SM_STD_NS = 13_000,  SM_OD_NS = 1_750;
  localparam int unsigned SL_STD_NS = 70_000,  SL_OD_NS = 12_000;

  function automatic int unsigned ns2cyc(int unsigned hz, int unsigned ns);
    longint unsigned c;
    c = (64'(hz) * 64'(ns)) / 64'd1_000_000_000;
    return (c == 0) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/owm_timing.sv
module owm_timing
  import owm_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned CW     = 17
) (
  input  logic          od_i,
  output logic [CW-1:0] t_rl_o,
  output logic [CW-1:0] t_ps_o,
  output logic [CW-1:0] t_re_o,
  output logic [CW-1:0] t_w0_o,
  output logic [CW-1:0] t_w1_o,
  output logic [CW-1:0] t_rd_o,
  output logic [CW-1:0] t_sm_o,
  output logic [CW-1:0] t_sl_o
);
  localparam int unsigned NT = 8;
  localparam int unsigned STD_NS [NT] = '{RL_STD_NS, PS_STD_NS, RE_STD_NS, W0_STD_NS,
                                          W1_STD_NS, RD_STD_NS, SM_STD_NS, SL_STD_NS};
  localparam int unsigned OD_NS  [NT] = '{RL_OD_NS, PS_OD_NS, RE_OD_NS, W0_OD_NS,
                                          W1_OD_NS, RD_OD_NS, SM_OD_NS, SL_OD_NS};

  logic [CW-1:0] sel [NT];

  for (genvar i = 0; i < NT; i++) begin : g_sel
    localparam logic [CW-1:0] C_STD = CW'(ns2cyc(CLK_HZ, STD_NS[i]));
    localparam logic [CW-1:0] C_OD  = CW'(ns2cyc(CLK_HZ, OD_NS[i]));
    assign sel[i] = od_i ? C_OD : C_STD;
  end

  assign t_rl_o = sel[0];
  assign t_ps_o = sel[1];
  assign t_re_o = sel[2];
  assign t_w0_o = sel[3];
  assign t_w1_o = sel[4];
  assign t_rd_o = sel[5];
  assign t_sm_o = sel[6];
  assign t_sl_o = sel[7];
endmodule

// File: rtl/owm_seq.sv
module owm_seq
  import owm_pkg::*;
#(
  parameter int unsigned CW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          od_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_i,
  input  logic          wbit_i,
  input  logic          line_s_i,
  input  logic [CW-1:0] t_rl_i,
  input  logic [CW-1:0] t_ps_i,
  input  logic [CW-1:0] t_re_i,
  input  logic [CW-1:0] t_w0_i,
  input  logic [CW-1:0] t_w1_i,
  input  logic [CW-1:0] t_rd_i,
  input  logic [CW-1:0] t_sm_i,
  input  logic [CW-1:0] t_sl_i,
  output logic          od_q_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          presence_o,
  output logic          rbit_o,
  output logic          short_o,
  output logic          line_oe_o
);
  owm_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          od_q, rd_q, wb_q, done_q, pres_q, rbit_q, short_q;
  logic          accept;
  logic [CW-1:0] t_low;
  owm_cmd_e      cmd;

  assign cmd    = owm_cmd_e'(cmd_i);
  assign accept = (state_q == S_IDLE) && cmd_valid_i && (cmd != CMD_RSVD);
  assign t_low  = rd_q ? t_rd_i : (wb_q ? t_w1_i : t_w0_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      od_q    <= 1'b0;
      rd_q    <= 1'b0;
      wb_q    <= 1'b0;
      done_q  <= 1'b0;
      pres_q  <= 1'b0;
      rbit_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      cnt_q  <= cnt_q + 1'b1;
      unique case (state_q)
        S_IDLE: begin
          cnt_q <= '0;
          if (accept) begin
            od_q    <= od_i;
            short_q <= 1'b0;
            unique case (cmd)
              CMD_RST: begin
                pres_q <= 1'b0;
                if (!line_s_i) begin
                  short_q <= 1'b1;
                  state_q <= S_ABORT;
                end else begin
                  state_q <= S_RST_LOW;
                end
              end
              CMD_WR: begin
                rd_q    <= 1'b0;
                wb_q    <= wbit_i;
                state_q <= S_SLOT;
              end
              default: begin
                rd_q    <= 1'b1;
                state_q <= S_SLOT;
              end
            endcase
          end
        end
        S_ABORT: begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
        end
        S_RST_LOW: begin
          if (cnt_q == t_rl_i - 1'b1) begin
            cnt_q   <= '0;
            state_q <= S_RST_WAIT;
          end
        end
        S_RST_WAIT: begin
          if (cnt_q == t_ps_i) pres_q <= !line_s_i;
          if (cnt_q == t_re_i - 1'b1) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end
        end
        S_SLOT: begin
          if (rd_q && cnt_q == t_sm_i) rbit_q <= line_s_i;
          if (cnt_q == t_sl_i - 1'b1) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign line_oe_o  = (state_q == S_RST_LOW) || ((state_q == S_SLOT) && (cnt_q < t_low));
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign presence_o = pres_q;
  assign rbit_o     = rbit_q;
  assign short_o    = short_q;
  assign od_q_o     = od_q;

  // R8: strobe lasts one cycle
  a_r8_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R8: busy ends only together with done
  a_r8_busy_ends_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_q);
  // R4: line is pulled only inside an operation
  a_r4_drive_only_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_oe_o |-> busy_o);
  // R9: speed held while an operation runs
  a_r9_speed_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> $stable(od_q));
  // R10: reserved code never starts an operation
  a_r10_rsvd_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && cmd_i == 2'b11) |=> (state_q == S_IDLE));
endmodule

// File: rtl/owm_master.sv
module owm_master
  import owm_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       od_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_i,
  input  logic       wbit_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       presence_o,
  output logic       rbit_o,
  output logic       short_o,
  input  logic       line_i,
  output logic       line_oe_o
);
  localparam int unsigned CW = $clog2(ns2cyc(CLK_HZ, RL_STD_NS) + 1) + 1;

  logic          line_s, od_q;
  logic [CW-1:0] t_rl, t_ps, t_re, t_w0, t_w1, t_rd, t_sm, t_sl;

  owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  owm_timing #(.CLK_HZ(CLK_HZ), .CW(CW)) u_timing (
    .od_i  (od_q),
    .t_rl_o(t_rl),
    .t_ps_o(t_ps),
    .t_re_o(t_re),
    .t_w0_o(t_w0),
    .t_w1_o(t_w1),
    .t_rd_o(t_rd),
    .t_sm_o(t_sm),
    .t_sl_o(t_sl)
  );

  owm_seq #(.CW(CW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .od_i       (od_i),
    .cmd_valid_i(cmd_valid_i),
    .cmd_i      (cmd_i),
    .wbit_i     (wbit_i),
    .line_s_i   (line_s),
    .t_rl_i     (t_rl),
    .t_ps_i     (t_ps),
    .t_re_i     (t_re),
    .t_w0_i     (t_w0),
    .t_w1_i     (t_w1),
    .t_rd_i     (t_rd),
    .t_sm_i     (t_sm),
    .t_sl_i     (t_sl),
    .od_q_o     (od_q),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .presence_o (presence_o),
    .rbit_o     (rbit_o),
    .short_o    (short_o),
    .line_oe_o  (line_oe_o)
  );
endmodule

// File: tb/owm_master_test.sv
module owm_master_test;
  localparam int unsigned HZ = 4_000_000;
  localparam int US = 4;  // cycles per us at HZ

  function automatic int cyc(int unsigned ns);
    return int'((64'(HZ) * 64'(ns)) / 64'd1_000_000_000);
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  logic od = 1'b0, cmd_valid = 1'b0, wbit = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic busy, done, presence, rbit, short_f, oe;
  logic slave_pull = 1'b0;
  logic line;
  int   checks = 0, errors = 0;
  int   slave_mode = 0;  // 1 presence, 2 read-zero
  int   s_start = 0, s_len = 0;
  bit   finished = 0;

  assign line = !(oe || slave_pull);
  always #5 clk = ~clk;

  owm_master #(.CLK_HZ(HZ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .od_i(od), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .wbit_i(wbit), .busy_o(busy), .done_o(done), .presence_o(presence), .rbit_o(rbit),
    .short_o(short_f), .line_i(line), .line_oe_o(oe)
  );

  always @(negedge oe) if (slave_mode == 1) begin
    repeat (s_start) @(negedge clk);
    slave_pull = 1'b1;
    repeat (s_len) @(negedge clk);
    slave_pull = 1'b0;
  end

  always @(posedge oe) if (slave_mode == 2) begin
    slave_pull = 1'b1;
    repeat (s_len) @(negedge clk);
    slave_pull = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] c, input logic wb, input logic sp, input bit inject,
                        output int lowc, output int totc, output bit busy_bad);
    lowc = 0; totc = 0; busy_bad = 0;
    @(negedge clk);
    od = sp; cmd = c; wbit = wb; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (inject) begin cmd = 2'b10; od = !sp; end
    while (!done && totc < 20000) begin
      if (oe) lowc++;
      if (!busy) busy_bad = 1;
      if (inject) cmd_valid = (totc == 10);
      totc++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
  endtask

  task automatic after_done(input string req);
    chk(busy == 1'b0, req, busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  task automatic t_reset_state();
    chk(oe == 0 && busy == 0 && done == 0, "R1 idle outputs", {oe, busy, done}, 0);
    chk(presence == 0 && rbit == 0 && short_f == 0, "R1 flags", {presence, rbit, short_f}, 0);
  endtask

  task automatic t_reset(input logic sp, input bit present);
    int lo, tot; bit bb;
    int e_lo  = sp ? cyc(56_000) : cyc(500_000);
    int e_tot = e_lo + (sp ? cyc(48_000) : cyc(480_000));
    slave_mode = present ? 1 : 0;
    s_start = sp ? 3 * US : 20 * US;
    s_len   = sp ? 12 * US : 100 * US;
    run_op(2'b00, 1'b0, sp, 0, lo, tot, bb);
    chk(lo == e_lo, "R2 reset low cycles", lo, e_lo);
    chk(tot == e_tot, "R2 reset total cycles", tot, e_tot);
    chk(presence == present, "R3 presence", presence, present);
    chk(!bb, "R8 busy during reset", bb, 0);
    chk(short_f == 0, "R4 no short", short_f, 0);
    after_done("R8 busy after reset");
    slave_mode = 0;
  endtask

  task automatic t_short();
    int lo, tot; bit bb;
    slave_pull = 1'b1;
    repeat (4) @(negedge clk);
    run_op(2'b00, 1'b0, 1'b0, 0, lo, tot, bb);
    chk(lo == 0, "R4 no drive on short", lo, 0);
    chk(tot == 1, "R4 short done after one busy cycle", tot, 1);
    chk(short_f == 1 && presence == 0, "R4 short flag", {short_f, presence}, 2);
    slave_pull = 1'b0;
    after_done("R4 busy after short");
  endtask

  task automatic t_write(input logic sp, input logic b);
    int lo, tot; bit bb;
    int e_lo  = b ? (sp ? cyc(1_000) : cyc(6_000)) : (sp ? cyc(8_000) : cyc(65_000));
    int e_tot = sp ? cyc(12_000) : cyc(70_000);
    run_op(2'b01, b, sp, 0, lo, tot, bb);
    if (b) chk(lo == e_lo, "R6 write-one low", lo, e_lo);
    else   chk(lo == e_lo, "R5 write-zero low", lo, e_lo);
    chk(tot == e_tot, "R5 slot length", tot, e_tot);
    chk(!bb, "R8 busy in slot", bb, 0);
    chk(lo == e_lo && tot == e_tot, "R11 speed select", sp, sp);
    after_done("R8 busy after write");
  endtask

  task automatic t_read(input logic sp, input logic b);
    int lo, tot; bit bb;
    int e_lo  = sp ? cyc(1_000) : cyc(6_000);
    int e_tot = sp ? cyc(12_000) : cyc(70_000);
    slave_mode = b ? 0 : 2;
    s_len = sp ? 4 * US : 30 * US;
    run_op(2'b10, 1'b0, sp, 0, lo, tot, bb);
    chk(lo == e_lo, "R7 read low", lo, e_lo);
    chk(tot == e_tot, "R7 read slot length", tot, e_tot);
    chk(rbit == b, "R7 read bit", rbit, b);
    after_done("R8 busy after read");
    slave_mode = 0;
  endtask

  task automatic t_busy_ignore();
    int lo, tot; bit bb;
    run_op(2'b01, 1'b0, 1'b0, 1, lo, tot, bb);
    chk(lo == cyc(65_000), "R9 low kept under late command", lo, cyc(65_000));
    chk(tot == cyc(70_000), "R9 slot kept under speed change", tot, cyc(70_000));
    after_done("R9 busy after ignored command");
    for (int i = 0; i < 10; i++) begin
      chk(!oe && !busy, "R9 no deferred operation", {oe, busy}, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_rsvd();
    @(negedge clk);
    cmd = 2'b11; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk(!oe && !busy && !done, "R10 reserved code ignored", {oe, busy, done}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_reset(1'b0, 1);
    t_reset(1'b0, 0);
    t_reset(1'b1, 1);
    t_reset(1'b1, 0);
    t_short();
    t_write(1'b0, 1'b0);
    t_write(1'b0, 1'b1);
    t_write(1'b1, 1'b0);
    t_write(1'b1, 1'b1);
    t_read(1'b0, 1'b1);
    t_read(1'b0, 1'b0);
    t_read(1'b1, 1'b1);
    t_read(1'b1, 1'b0);
    t_busy_ignore();
    t_rsvd();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule